// File: doc/BRIEF.md
# Sliding-Window Calorimeter Level-0 Trigger

This block makes a fast accept decision for a calorimeter region. Each bunch period it receives one 12-bit sample from each of 112 analogue trigger sums. These channels form a grid of 14 columns by 8 rows. A per-channel pedestal is removed from every sample. Every overlapping 2-by-2 patch of neighbouring channels is then added up, which gives a 13-by-7 grid of 91 window sums. Each window sum is also added over the five most recent bunches. The block raises the level-0 accept when any of the 91 space-time sums exceeds one shared threshold.

When the block accepts, it copies all 91 space-time sums of that bunch into a hold buffer. The buffer keeps them until it is released. Readout software fetches the held sums one window at a time through an indexed read port. An enable register can silence the accept while the summing pipeline keeps running. A later accept that finds the buffer still held is reported as an overrun.

Top module: `l0_sliding_trigger`

## Requirements
- R1: The corrected sample of each channel is its raw sample minus that channel's pedestal, and is 0 whenever the pedestal is equal to or larger than the raw value. Pedestals reset to 0 and are written through `ped_we`/`ped_idx`/`ped_val`.
- R2: Window (r, c), with r from 0 to 6 and c from 0 to 12, adds the corrected samples of channels r*14+c, r*14+c+1, (r+1)*14+c and (r+1)*14+c+1. Channel k is the bits `smp_raw[k*12 +: 12]`. The window's index is r*13+c.
- R3: Each window's space-time sum is the total of its last five window sums, counting only bunches with `smp_valid` high. A single non-zero bunch therefore adds to exactly five valid bunches. Cycles with `smp_valid` low neither move the window nor raise the accept.
- R4: The accept is set when at least one of the 91 space-time sums is strictly greater than the threshold.
- R5: A sample set taken on rising edge k affects `l0_accept` right after rising edge k+3.
- R6: After reset, `l0_accept` stays low until five valid sample sets have been fully summed.
- R7: While the enable is 0, `l0_accept` stays low and no sums are held, but the pipeline keeps running. Once the enable is set, the accept reflects the current sums with no new warm-up.
- R8: An accept while the buffer is open copies all 91 space-time sums of that bunch and sets `frozen` on the same edge.
- R9: While the buffer is held, accepts are still output, the held sums do not change, and `overrun` is set. A pulse on `frz_clr` clears both `frozen` and `overrun`.
- R10: `rd_data` gives the held sum of window `rd_idx` after the next rising edge, and does not change before that edge.
- R11: After reset, `l0_accept`, `frozen`, `overrun` and `rd_data` are 0, the enable is 0 and the threshold is all ones, so even full-scale input cannot set the accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new sample set is present |
| smp_raw | input | 1344 | 112 raw samples, channel k at bits k*12 +: 12 |
| ped_we | input | 1 | Pedestal write strobe |
| ped_idx | input | 7 | Channel whose pedestal is written |
| ped_val | input | 12 | Pedestal value |
| en_we | input | 1 | Enable write strobe |
| en_val | input | 1 | New enable value |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | 17 | New threshold value |
| frz_clr | input | 1 | Releases the hold buffer and clears overrun |
| rd_idx | input | 7 | Window index to read |
| rd_data | output | 17 | Held sum of the requested window |
| l0_accept | output | 1 | Level-0 accept |
| frozen | output | 1 | The hold buffer contains a capture |
| overrun | output | 1 | An accept came while the buffer was held |

## Verification
The bench targets the edges of the compare and of the five-bunch window:
- Sums equal to the threshold must not fire. A design that compares with greater-or-equal would fire on them.
- A single impulse must give exactly five accept cycles, both with and without gaps in `smp_valid`. A delay line of the wrong depth, or one that shifts on idle cycles, would change that count.
- The accept must appear exactly on the cycle after five bunches, no sooner and no later. An off-by-one warm-up counter would move it.
- Pedestals larger than the sample must clamp to zero. A subtractor that wraps around would add a huge sum.
- Impulses placed at the grid's last corner and in its interior show whether the row-major window numbering is wrong.
- A second impulse while the buffer is held shows whether the buffer is overwritten.

// File: rtl/l0trig_pkg.sv
package l0trig_pkg;

    parameter int GRID_COLS  = 14;
    parameter int GRID_ROWS  = 8;
    parameter int SAMPLE_W   = 12;
    parameter int HIST_DEPTH = 5;

    localparam int NUM_CH    = GRID_COLS * GRID_ROWS;
    localparam int WIN_COLS  = GRID_COLS - 1;
    localparam int WIN_ROWS  = GRID_ROWS - 1;
    localparam int NUM_WIN   = WIN_COLS * WIN_ROWS;
    localparam int SSUM_W    = SAMPLE_W + 2;
    localparam int TSUM_W    = SSUM_W + $clog2(HIST_DEPTH);
    localparam int CH_IDX_W  = $clog2(NUM_CH);
    localparam int WIN_IDX_W = $clog2(NUM_WIN);

    typedef enum logic [1:0] {
        HOLD_OPEN    = 2'd0,
        HOLD_FULL    = 2'd1,
        HOLD_OVERRUN = 2'd2
    } hold_state_e;

    function automatic int win_index(input int row, input int col, input int wcols);
        return row * wcols + col;
    endfunction

endpackage

// File: rtl/l0_ped_sub.sv
module l0_ped_sub #(
    parameter int NCH  = l0trig_pkg::NUM_CH,
    parameter int SW   = l0trig_pkg::SAMPLE_W,
    localparam int CIW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [NCH*SW-1:0] smp_raw,
    input  logic              ped_we,
    input  logic [CIW-1:0]    ped_idx,
    input  logic [SW-1:0]     ped_val,
    output logic              cor_vld,
    output logic [NCH*SW-1:0] cor_data
);

    logic [SW-1:0] ped_q [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) ped_q[i] <= '0;
        end else if (ped_we && (int'(ped_idx) < NCH)) begin
            ped_q[ped_idx] <= ped_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cor_vld  <= 1'b0;
            cor_data <= '0;
        end else begin
            cor_vld <= smp_valid;
            if (smp_valid) begin
                for (int i = 0; i < NCH; i++) begin
                    cor_data[i*SW +: SW] <= (smp_raw[i*SW +: SW] > ped_q[i])
                                          ? smp_raw[i*SW +: SW] - ped_q[i] : '0;
                end
            end
        end
    end

    // R1: a sample at or below its pedestal clamps to zero
    a_r1_clamp_zero: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (smp_raw[SW-1:0] <= ped_q[0])) |=> (cor_data[SW-1:0] == '0));

    // R1: correction never raises a sample
    a_r1_not_above_raw: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> (cor_data[SW-1:0] <= $past(smp_raw[SW-1:0])));

endmodule

// File: rtl/l0_win_sum.sv
module l0_win_sum #(
    parameter int COLS  = l0trig_pkg::GRID_COLS,
    parameter int ROWS  = l0trig_pkg::GRID_ROWS,
    parameter int SW    = l0trig_pkg::SAMPLE_W,
    localparam int NCH  = COLS * ROWS,
    localparam int WCOLS = COLS - 1,
    localparam int WROWS = ROWS - 1,
    localparam int NWIN = WCOLS * WROWS,
    localparam int SSW  = SW + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [NCH*SW-1:0]   in_data,
    output logic                ws_vld,
    output logic [NWIN*SSW-1:0] ws_data
);

    always_ff @(posedge clk) begin
        if (rst) ws_vld <= 1'b0;
        else     ws_vld <= in_vld;
    end

    for (genvar r = 0; r < WROWS; r++) begin : g_row
        for (genvar c = 0; c < WCOLS; c++) begin : g_col
            localparam int W   = l0trig_pkg::win_index(r, c, WCOLS);
            localparam int C00 = r * COLS + c;
            localparam int C10 = (r + 1) * COLS + c;
            logic [SSW-1:0] patch;

            always_comb begin
                patch = {2'b00, in_data[C00*SW +: SW]}
                      + {2'b00, in_data[(C00+1)*SW +: SW]}
                      + {2'b00, in_data[C10*SW +: SW]}
                      + {2'b00, in_data[(C10+1)*SW +: SW]};
            end

            always_ff @(posedge clk) begin
                if (rst)         ws_data[W*SSW +: SSW] <= '0;
                else if (in_vld) ws_data[W*SSW +: SSW] <= patch;
            end
        end
    end

    // R2: window sums only move on valid bunches
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(ws_data));

endmodule

// File: rtl/l0_time_sum.sv
module l0_time_sum #(
    parameter int NWIN  = l0trig_pkg::NUM_WIN,
    parameter int SSW   = l0trig_pkg::SSUM_W,
    parameter int DEPTH = l0trig_pkg::HIST_DEPTH,
    localparam int TSW  = SSW + $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ws_vld,
    input  logic [NWIN*SSW-1:0] ws_data,
    output logic                ts_vld,
    output logic                ts_full,
    output logic [NWIN*TSW-1:0] ts_data
);

    localparam int PAD = TSW - SSW;
    localparam logic [TSW-1:0] TS_MAX = TSW'(DEPTH * 4 * ((1 << (SSW - 2)) - 1));

    logic [CNTW-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_vld   <= 1'b0;
            ts_full  <= 1'b0;
            fill_cnt <= '0;
        end else begin
            ts_vld <= ws_vld;
            if (ws_vld && !ts_full) begin
                fill_cnt <= fill_cnt + 1'b1;
                ts_full  <= (fill_cnt == CNTW'(DEPTH - 1));
            end
        end
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [SSW-1:0] hist [DEPTH];
        logic [TSW-1:0] acc;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int d = 0; d < DEPTH; d++) hist[d] <= '0;
                acc <= '0;
            end else if (ws_vld) begin
                hist[0] <= ws_data[w*SSW +: SSW];
                for (int d = 1; d < DEPTH; d++) hist[d] <= hist[d-1];
                acc <= acc + {{PAD{1'b0}}, ws_data[w*SSW +: SSW]}
                           - {{PAD{1'b0}}, hist[DEPTH-1]};
            end
        end

        assign ts_data[w*TSW +: TSW] = acc;
    end

    // R3: the running sum never leaves the range of five full windows
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ts_data[TSW-1:0] <= TS_MAX);

    // R6: the fill flag rises only with a valid update
    a_r6_full_on_update: assert property (@(posedge clk) disable iff (rst)
        $rose(ts_full) |-> ts_vld);

endmodule

// File: rtl/l0_sliding_trigger.sv
module l0_sliding_trigger #(
    parameter int GRID_COLS  = l0trig_pkg::GRID_COLS,
    parameter int GRID_ROWS  = l0trig_pkg::GRID_ROWS,
    parameter int SAMPLE_W   = l0trig_pkg::SAMPLE_W,
    parameter int HIST_DEPTH = l0trig_pkg::HIST_DEPTH,
    localparam int NCH  = GRID_COLS * GRID_ROWS,
    localparam int NWIN = (GRID_COLS - 1) * (GRID_ROWS - 1),
    localparam int SSW  = SAMPLE_W + 2,
    localparam int TSW  = SSW + $clog2(HIST_DEPTH),
    localparam int CIW  = $clog2(NCH),
    localparam int WIW  = $clog2(NWIN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic [NCH*SAMPLE_W-1:0] smp_raw,
    input  logic                    ped_we,
    input  logic [CIW-1:0]          ped_idx,
    input  logic [SAMPLE_W-1:0]     ped_val,
    input  logic                    en_we,
    input  logic                    en_val,
    input  logic                    thr_we,
    input  logic [TSW-1:0]          thr_val,
    input  logic                    frz_clr,
    input  logic [WIW-1:0]          rd_idx,
    output logic [TSW-1:0]          rd_data,
    output logic                    l0_accept,
    output logic                    frozen,
    output logic                    overrun
);
    import l0trig_pkg::*;

    logic                    cor_vld, ws_vld, ts_vld, ts_full;
    logic [NCH*SAMPLE_W-1:0] cor_data;
    logic [NWIN*SSW-1:0]     ws_data;
    logic [NWIN*TSW-1:0]     ts_data;

    l0_ped_sub #(.NCH(NCH), .SW(SAMPLE_W)) u_ped (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_raw(smp_raw),
        .ped_we(ped_we), .ped_idx(ped_idx), .ped_val(ped_val),
        .cor_vld(cor_vld), .cor_data(cor_data));

    l0_win_sum #(.COLS(GRID_COLS), .ROWS(GRID_ROWS), .SW(SAMPLE_W)) u_win (
        .clk(clk), .rst(rst), .in_vld(cor_vld), .in_data(cor_data),
        .ws_vld(ws_vld), .ws_data(ws_data));

    l0_time_sum #(.NWIN(NWIN), .SSW(SSW), .DEPTH(HIST_DEPTH)) u_time (
        .clk(clk), .rst(rst), .ws_vld(ws_vld), .ws_data(ws_data),
        .ts_vld(ts_vld), .ts_full(ts_full), .ts_data(ts_data));

    logic           en_q;
    logic [TSW-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            thr_q <= '1;
        end else begin
            if (en_we)  en_q  <= en_val;
            if (thr_we) thr_q <= thr_val;
        end
    end

    logic any_hit, fire;

    always_comb begin
        any_hit = 1'b0;
        for (int w = 0; w < NWIN; w++) begin
            if (ts_data[w*TSW +: TSW] > thr_q) any_hit = 1'b1;
        end
        fire = ts_vld && ts_full && en_q && any_hit;
    end

    hold_state_e    hold_q;
    logic [TSW-1:0] frz_q [NWIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            l0_accept <= 1'b0;
            hold_q    <= HOLD_OPEN;
            for (int w = 0; w < NWIN; w++) frz_q[w] <= '0;
        end else begin
            l0_accept <= fire;
            if (frz_clr) begin
                hold_q <= HOLD_OPEN;
            end else if (fire) begin
                if (hold_q == HOLD_OPEN) begin
                    hold_q <= HOLD_FULL;
                    for (int w = 0; w < NWIN; w++) frz_q[w] <= ts_data[w*TSW +: TSW];
                end else begin
                    hold_q <= HOLD_OVERRUN;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         rd_data <= '0;
        else if (int'(rd_idx) < NWIN)    rd_data <= frz_q[rd_idx];
        else                             rd_data <= '0;
    end

    assign frozen  = (hold_q != HOLD_OPEN);
    assign overrun = (hold_q == HOLD_OVERRUN);

    // R7: a cleared enable keeps the accept low
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !l0_accept);

    // R6: no accept before the history is filled
    a_r6_warm_before_fire: assert property (@(posedge clk) disable iff (rst)
        l0_accept |-> ts_full);

    // R8: an accept always leaves the buffer held unless it was just released
    a_r8_accept_holds: assert property (@(posedge clk) disable iff (rst)
        (l0_accept && !$past(frz_clr)) |-> frozen);

    // R9: a held buffer stays held until released
    a_r9_hold_sticky: assert property (@(posedge clk) disable iff (rst)
        (frozen && !frz_clr) |=> frozen);

    // R9: overrun is only reported on a held buffer
    a_r9_overrun_needs_hold: assert property (@(posedge clk) disable iff (rst)
        overrun |-> frozen);

endmodule

// File: tb/l0_sliding_trigger_tb_top.sv
`timescale 1ns/1ps
module l0_sliding_trigger_tb_top;

    localparam int NCH = 112;
    localparam int SW  = 12;
    localparam int TSW = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic [NCH*SW-1:0] smp_raw = '0;
    logic              ped_we = 1'b0;
    logic [6:0]        ped_idx = '0;
    logic [SW-1:0]     ped_val = '0;
    logic              en_we = 1'b0, en_val = 1'b0;
    logic              thr_we = 1'b0;
    logic [TSW-1:0]    thr_val = '0;
    logic              frz_clr = 1'b0;
    logic [6:0]        rd_idx = '0;
    logic [TSW-1:0]    rd_data;
    logic              l0_accept, frozen, overrun;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    l0_sliding_trigger dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_raw(smp_raw),
        .ped_we(ped_we), .ped_idx(ped_idx), .ped_val(ped_val),
        .en_we(en_we), .en_val(en_val), .thr_we(thr_we), .thr_val(thr_val),
        .frz_clr(frz_clr), .rd_idx(rd_idx), .rd_data(rd_data),
        .l0_accept(l0_accept), .frozen(frozen), .overrun(overrun));

    typedef struct packed {
        logic [11:0] lvl;
        logic [16:0] thr;
        logic        exp;
    } vec_t;

    // uniform fill lvl gives 20*lvl in every window
    localparam vec_t VEC [6] = '{
        '{12'd100,  17'd1999,  1'b1},
        '{12'd100,  17'd2000,  1'b0},
        '{12'd0,    17'd0,     1'b0},
        '{12'd4095, 17'd81899, 1'b1},
        '{12'd4095, 17'd81900, 1'b0},
        '{12'd1,    17'd19,    1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [11:0] v);
        for (int k = 0; k < NCH; k++) smp_raw[k*SW +: SW] = v;
    endtask

    task automatic set_ch(input int k, input logic [11:0] v);
        smp_raw[k*SW +: SW] = v;
    endtask

    task automatic wr_ped(input int k, input logic [11:0] v);
        ped_we = 1'b1; ped_idx = 7'(k); ped_val = v;
        tick(1);
        ped_we = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        en_we = 1'b1; en_val = v;
        tick(1);
        en_we = 1'b0;
    endtask

    task automatic wr_thr(input logic [16:0] v);
        thr_we = 1'b1; thr_val = v;
        tick(1);
        thr_we = 1'b0;
    endtask

    task automatic release_hold();
        frz_clr = 1'b1;
        tick(1);
        frz_clr = 1'b0;
    endtask

    task automatic rd(input int w, input longint exp, input string tag);
        rd_idx = 7'(w);
        tick(1);
        chk(tag, rd_data, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int acc_cnt;
        tick(1);
        do_reset();

        // R11 reset state
        chk("R11 accept", l0_accept, 0);
        chk("R11 frozen", frozen, 0);
        chk("R11 overrun", overrun, 0);
        chk("R11 rd_data", rd_data, 0);

        // R11 threshold resets to all ones: full scale never fires
        wr_en(1'b1);
        fill(12'hFFF);
        smp_valid = 1'b1;
        tick(12);
        chk("R11 no fire at reset threshold", l0_accept, 0);
        chk("R11 nothing held", frozen, 0);

        // R6/R5/R1/R8 warm-up from fresh reset
        do_reset();
        wr_ped(0, 12'd100);
        wr_ped(1, 12'd80);
        wr_en(1'b1);
        wr_thr(17'd0);
        fill(12'd0);
        set_ch(0, 12'd300);
        set_ch(1, 12'd50);
        smp_valid = 1'b1;
        tick(7);
        chk("R6 no accept after four summed sets", l0_accept, 0);
        tick(1);
        chk("R5 R6 accept on fifth set", l0_accept, 1);
        chk("R8 frozen on first accept", frozen, 1);
        rd(0, 1000, "R1 R8 window 0 with pedestal");
        rd(1, 0, "R1 clamp to zero");
        chk("R9 overrun on repeat accept", overrun, 1);

        // R2 window mapping
        wr_en(1'b0);
        fill(12'd0);
        set_ch(111, 12'd1000);
        set_ch(47, 12'd10);
        tick(10);
        release_hold();
        wr_en(1'b1);
        tick(1);
        chk("R2 held after enable", frozen, 1);
        rd(90, 5000, "R2 corner window 90");
        rd(30, 50, "R2 window 30");
        rd(31, 50, "R2 window 31");
        rd(43, 50, "R2 window 43");
        rd(44, 50, "R2 window 44");
        rd(32, 0, "R2 window 32 untouched");
        // R10 no change before the next edge
        rd_idx = 7'd90;
        #1;
        chk("R10 read waits for edge", rd_data, 0);
        tick(1);
        chk("R10 read after edge", rd_data, 5000);

        // R7 enable gating with pipeline running
        wr_en(1'b0);
        release_hold();
        wr_thr(17'd100);
        fill(12'd100);
        tick(12);
        chk("R7 disabled accept", l0_accept, 0);
        chk("R7 disabled no hold", frozen, 0);
        wr_en(1'b1);
        chk("R7 not before enable lands", l0_accept, 0);
        tick(1);
        chk("R7 fires without new warm-up", l0_accept, 1);

        // R3/R5 impulse on contiguous bunches
        wr_en(1'b0);
        wr_thr(17'd0);
        fill(12'd0);
        tick(10);
        release_hold();
        wr_en(1'b1);
        set_ch(0, 12'd104);
        tick(1);
        set_ch(0, 12'd0);
        tick(2);
        chk("R5 not before third edge", l0_accept, 0);
        acc_cnt = 0;
        for (int i = 0; i < 5; i++) begin
            tick(1);
            if (l0_accept) acc_cnt++;
        end
        chk("R3 R5 five consecutive accepts", acc_cnt, 5);
        tick(1);
        chk("R3 impulse leaves after five", l0_accept, 0);
        rd(0, 4, "R8 held impulse sum");
        chk("R9 overrun after later accepts", overrun, 1);

        // R3 impulse with idle gaps, R9 no overwrite
        set_ch(0, 12'd109);
        smp_valid = 1'b1;
        acc_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (l0_accept) acc_cnt++;
            set_ch(0, 12'd0);
            smp_valid = (i % 2 == 1);
        end
        chk("R3 five accepts across idle gaps", acc_cnt, 5);
        rd(0, 4, "R9 held sum not overwritten");
        smp_valid = 1'b1;
        release_hold();
        chk("R9 clear releases hold", frozen, 0);
        chk("R9 clear drops overrun", overrun, 0);

        // R4 compare table
        wr_ped(0, 12'd0);
        wr_ped(1, 12'd0);
        for (int v = 0; v < 6; v++) begin
            wr_en(1'b0);
            wr_thr(VEC[v].thr);
            fill(VEC[v].lvl);
            tick(10);
            release_hold();
            wr_en(1'b1);
            tick(1);
            chk($sformatf("R4 vector %0d accept", v), l0_accept, VEC[v].exp);
            chk($sformatf("R4 vector %0d hold", v), frozen, VEC[v].exp);
            if (VEC[v].exp) rd(45, 20 * VEC[v].lvl, $sformatf("R8 vector %0d held sum", v));
        end

        finish_run();
    end

endmodule